// File: doc/BRIEF.md
# Endpoint DMA Descriptor Fetch Controller

This block sits between a USB device endpoint engine and its descriptor memory. For every DMA trigger raised for a physical endpoint, it decides whether the descriptor it already holds can be used again or whether a fresh one must be loaded. A fresh load reads the endpoint's slot in a pointer table, then the two descriptor words that the pointer names. When a packet finishes, the block advances the transfer count of the active descriptor and retires the descriptor once the count covers the buffer length.

Triggers are only taken while the controller is idle. Triggers for the two default control endpoints are refused, and so are triggers for endpoints whose enable bit is clear. When the packet before was for the same endpoint and the held descriptor has not retired, the block skips memory entirely and raises a proceed flag. The memory port issues at most one word read per cycle, and the data returns a fixed `RD_LAT` cycles after the request.

Top module: `dd_fetch_ctrl`

## Requirements
- R1: A trigger for endpoint 0 or 1 is refused. `err` is high for one cycle after the trigger edge, no memory read is issued, and `busy` stays low.
- R2: A fetch reads word `PTR_BASE + ep` from the pointer table, then descriptor words at `ptr` and `ptr + 1`. Each read is one `mem_rd` cycle, and its data is taken `RD_LAT` cycles later. Word 0 holds the mode in bits [1:0], the isochronous flag in bit 2 and the buffer length in bits [31:16]. Word 1 holds the buffer address. The count starts at 0.
- R3: A trigger for an endpoint whose `dma_en` bit is clear is refused in the same way as R1.
- R4: A trigger for the endpoint already held, with its descriptor not retired, issues no memory read. It makes `active` and `proceed` high in the next cycle.
- R5: A descriptor whose mode field is not 2'b00 is rejected. `err` pulses and the controller returns to idle without going active.
- R6: A `pkt_done` pulse while active updates `dd_count` and returns the controller to idle. While active and without `pkt_done`, the count holds.
- R7: For an isochronous descriptor each packet adds 1 to the count. Otherwise each packet adds `pkt_bytes`.
- R8: When the count reaches or passes `dd_len`, `dd_retired` rises and `proceed` clears. The next trigger for that endpoint fetches again.
- R9: A trigger for a different endpoint clears `proceed` and starts a full fetch.
- R10: A pointer table entry of zero is treated as missing. `err` pulses and the controller returns to idle after the single pointer read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_valid | input | 1 | DMA trigger for `trig_ep` |
| trig_ep | input | EPW | Physical endpoint number of the trigger |
| dma_en | input | NUM_EP | Per-endpoint DMA enable bits |
| mem_rd | output | 1 | Memory word read request |
| mem_addr | output | AW | Word address of the read |
| mem_rdata | input | 32 | Read data, valid RD_LAT cycles after the request |
| pkt_done | input | 1 | Packet completed for the active descriptor |
| pkt_bytes | input | PKW | Byte count of the completed packet |
| busy | output | 1 | Controller is not idle |
| active | output | 1 | A descriptor is active and waits for a packet |
| proceed | output | 1 | Held descriptor was reused without a fetch |
| err | output | 1 | One-cycle refusal or descriptor error pulse |
| dd_ep | output | EPW | Endpoint of the held descriptor |
| dd_buf_addr | output | 32 | Buffer address of the held descriptor |
| dd_len | output | 16 | Buffer length of the held descriptor |
| dd_iso | output | 1 | Held descriptor is isochronous |
| dd_count | output | 16 | Present transfer count |
| dd_retired | output | 1 | Held descriptor has retired |

## Verification
The bench targets the reuse decision from several angles: a repeat trigger on a live descriptor, a repeat trigger after retirement, and a switch between endpoints. A design that got this wrong would either issue pointer reads it should skip or keep a stale descriptor for a new endpoint. Refusals are checked for endpoints 0 and 1 even with their enable bits set, and for an enabled-looking endpoint whose bit is clear. A design that tested only one condition would start a fetch there. The count is driven with an isochronous descriptor and large byte counts, so that a controller adding bytes instead of packets misses the retirement point. A bad mode field and a zero pointer must each end in an error rather than an active descriptor.

// File: rtl/dd_fetch_ctrl.sv
module dd_fetch_ctrl #(
  parameter int NUM_EP = 32,
  parameter int AW = 16,
  parameter int RD_LAT = 2,
  parameter logic [AW-1:0] PTR_BASE = 16'h0040,
  parameter int PKW = 11,
  localparam int EPW = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  input  logic [EPW-1:0]    trig_ep,
  input  logic [NUM_EP-1:0] dma_en,
  output logic              mem_rd,
  output logic [AW-1:0]     mem_addr,
  input  logic [31:0]       mem_rdata,
  input  logic              pkt_done,
  input  logic [PKW-1:0]    pkt_bytes,
  output logic              busy,
  output logic              active,
  output logic              proceed,
  output logic              err,
  output logic [EPW-1:0]    dd_ep,
  output logic [31:0]       dd_buf_addr,
  output logic [15:0]       dd_len,
  output logic              dd_iso,
  output logic [15:0]       dd_count,
  output logic              dd_retired
);
  localparam int LATW = $clog2(RD_LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_PTR, S_DD, S_ACTIVE} st_t;

  st_t             st;
  logic [LATW-1:0] lat;
  logic            word1;
  logic [AW-1:0]   ptr;
  logic            held;
  logic [16:0]     sum;
  logic [15:0]     cnt_nx;
  logic            ep_ok, hit, rd_now;

  assign ep_ok  = (trig_ep > EPW'(1)) && dma_en[trig_ep];
  assign hit    = held && !dd_retired && (trig_ep == dd_ep);
  assign rd_now = (lat == LATW'(RD_LAT));
  assign sum    = {1'b0, dd_count} + (dd_iso ? 17'd1 : 17'(pkt_bytes));
  assign cnt_nx = sum[16] ? 16'hFFFF : sum[15:0];

  assign busy     = (st != S_IDLE);
  assign active   = (st == S_ACTIVE);
  assign mem_rd   = (st == S_PTR || st == S_DD) && (lat == '0);
  assign mem_addr = (st == S_PTR) ? PTR_BASE + AW'(dd_ep) : ptr + AW'(word1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      lat         <= '0;
      word1       <= 1'b0;
      ptr         <= '0;
      held        <= 1'b0;
      proceed     <= 1'b0;
      err         <= 1'b0;
      dd_ep       <= '0;
      dd_buf_addr <= '0;
      dd_len      <= '0;
      dd_iso      <= 1'b0;
      dd_count    <= '0;
      dd_retired  <= 1'b0;
    end else begin
      err <= 1'b0;
      case (st)
        S_IDLE: if (trig_valid) begin
          if (!ep_ok) begin
            err <= 1'b1;
          end else if (hit) begin
            proceed <= 1'b1;
            st      <= S_ACTIVE;
          end else begin
            proceed    <= 1'b0;
            held       <= 1'b0;
            dd_ep      <= trig_ep;
            dd_count   <= '0;
            dd_retired <= 1'b0;
            lat        <= '0;
            st         <= S_PTR;
          end
        end
        S_PTR: begin
          if (rd_now) begin
            lat <= '0;
            if (mem_rdata[AW-1:0] == '0) begin
              err <= 1'b1;
              st  <= S_IDLE;
            end else begin
              ptr   <= mem_rdata[AW-1:0];
              word1 <= 1'b0;
              st    <= S_DD;
            end
          end else begin
            lat <= lat + LATW'(1);
          end
        end
        S_DD: begin
          if (rd_now) begin
            lat <= '0;
            if (!word1) begin
              if (mem_rdata[1:0] != 2'b00) begin
                err <= 1'b1;
                st  <= S_IDLE;
              end else begin
                dd_len <= mem_rdata[31:16];
                dd_iso <= mem_rdata[2];
                word1  <= 1'b1;
              end
            end else begin
              dd_buf_addr <= mem_rdata;
              dd_retired  <= (dd_len == 16'd0);
              held        <= 1'b1;
              st          <= S_ACTIVE;
            end
          end else begin
            lat <= lat + LATW'(1);
          end
        end
        S_ACTIVE: if (pkt_done) begin
          dd_count <= cnt_nx;
          if (cnt_nx >= dd_len) begin
            dd_retired <= 1'b1;
            proceed    <= 1'b0;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dd_fetch_ctrl_chk #(
  parameter int NUM_EP = 32,
  parameter int AW = 16,
  parameter logic [AW-1:0] PTR_BASE = 16'h0040,
  parameter int PKW = 11,
  localparam int EPW = $clog2(NUM_EP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trig_valid,
  input logic [EPW-1:0]    trig_ep,
  input logic [NUM_EP-1:0] dma_en,
  input logic              mem_rd,
  input logic [AW-1:0]     mem_addr,
  input logic              pkt_done,
  input logic              busy,
  input logic              active,
  input logic              proceed,
  input logic              err,
  input logic [EPW-1:0]    dd_ep,
  input logic              dd_iso,
  input logic [15:0]       dd_count,
  input logic [15:0]       dd_len,
  input logic              dd_retired
);
  AST_CTRL_EP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && !busy && trig_ep < EPW'(2) |=> err && !busy && !mem_rd); // R1
  AST_PTR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && !busy && trig_ep > EPW'(1) && dma_en[trig_ep] |=>
      (active && proceed && !mem_rd) || (mem_rd && mem_addr == PTR_BASE + AW'($past(trig_ep)))); // R2
  AST_DISABLED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && !busy && !dma_en[trig_ep] |=> err && !busy && !mem_rd); // R3
  AST_PROCEED_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    proceed |-> !dd_retired); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    active && !pkt_done |=> $stable(dd_count)); // R6
  AST_ISO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    active && pkt_done && dd_iso && dd_count != 16'hFFFF |=> dd_count == $past(dd_count) + 16'd1); // R7
  AST_RETIRE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    dd_retired |-> dd_count >= dd_len); // R8
  AST_EP_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && !busy && trig_ep != dd_ep |=> !proceed); // R9
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy); // R5
endmodule

bind dd_fetch_ctrl dd_fetch_ctrl_chk #(.NUM_EP(NUM_EP), .AW(AW), .PTR_BASE(PTR_BASE), .PKW(PKW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ep(trig_ep), .dma_en(dma_en),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .pkt_done(pkt_done), .busy(busy), .active(active),
  .proceed(proceed), .err(err), .dd_ep(dd_ep), .dd_iso(dd_iso), .dd_count(dd_count),
  .dd_len(dd_len), .dd_retired(dd_retired));

// File: tb/test_dd_fetch_ctrl.sv
module test_dd_fetch_ctrl;
  localparam int NUM_EP = 32;
  localparam int AW = 16;
  localparam int RD_LAT = 2;
  localparam int PKW = 11;
  localparam int EPW = $clog2(NUM_EP);

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_valid = 1'b0;
  logic [EPW-1:0] trig_ep = '0;
  logic [NUM_EP-1:0] dma_en;
  logic mem_rd;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_rdata;
  logic pkt_done = 1'b0;
  logic [PKW-1:0] pkt_bytes = '0;
  logic busy, active, proceed, err, dd_iso, dd_retired;
  logic [EPW-1:0] dd_ep;
  logic [31:0] dd_buf_addr;
  logic [15:0] dd_len, dd_count;

  int n_chk = 0, n_bad = 0;
  int rd_total = 0;
  logic [AW-1:0] rd_log [8];
  logic [31:0] mem [256];
  logic [31:0] rpipe [RD_LAT];

  always #2.5 clk = ~clk;

  dd_fetch_ctrl #(.NUM_EP(NUM_EP), .AW(AW), .RD_LAT(RD_LAT), .PTR_BASE(16'h0040), .PKW(PKW)) i_dd_fetch_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_ep(trig_ep), .dma_en(dma_en),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pkt_done(pkt_done),
    .pkt_bytes(pkt_bytes), .busy(busy), .active(active), .proceed(proceed), .err(err),
    .dd_ep(dd_ep), .dd_buf_addr(dd_buf_addr), .dd_len(dd_len), .dd_iso(dd_iso),
    .dd_count(dd_count), .dd_retired(dd_retired));

  assign mem_rdata = rpipe[RD_LAT-1];

  always @(posedge clk) begin
    for (int k = RD_LAT - 1; k > 0; k--) rpipe[k] <= rpipe[k-1];
    rpipe[0] <= mem_rd ? mem[mem_addr[7:0]] : 32'hDEAD_BEEF;
    if (mem_rd) begin
      rd_log[rd_total % 8] <= mem_addr;
      rd_total <= rd_total + 1;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int t_reads;
  logic t_err;

  task automatic trig(input int ep);
    int base;
    base = rd_total;
    t_err = 1'b0;
    @(negedge clk);
    trig_valid = 1'b1;
    trig_ep = EPW'(ep);
    @(negedge clk);
    trig_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (err) t_err = 1'b1;
      if (!busy || active) break;
      @(negedge clk);
    end
    t_reads = rd_total - base;
  endtask

  task automatic pkt(input int bytes);
    @(negedge clk);
    pkt_done = 1'b1;
    pkt_bytes = PKW'(bytes);
    @(negedge clk);
    pkt_done = 1'b0;
  endtask

  task automatic t_reset;
    check(busy, 0, "R6", "reset busy");
    check(active, 0, "R6", "reset active");
    check(proceed, 0, "R4", "reset proceed");
    check(err, 0, "R1", "reset err");
    check(dd_count, 0, "R6", "reset count");
  endtask

  task automatic t_ctrl_refused;
    trig(1);
    check(t_err, 1, "R1", "ep1 err");
    check(t_reads, 0, "R1", "ep1 reads");
    check(busy, 0, "R1", "ep1 busy");
    trig(0);
    check(t_err, 1, "R1", "ep0 err");
    check(t_reads, 0, "R1", "ep0 reads");
  endtask

  task automatic t_disabled;
    trig(4);
    check(t_err, 1, "R3", "disabled err");
    check(t_reads, 0, "R3", "disabled reads");
    check(busy, 0, "R3", "disabled busy");
  endtask

  task automatic t_first_fetch;
    int b;
    b = rd_total;
    trig(3);
    check(t_reads, 3, "R2", "fetch reads");
    check(rd_log[b % 8], 32'h43, "R2", "ptr addr");
    check(rd_log[(b + 1) % 8], 32'h80, "R2", "dd word0 addr");
    check(rd_log[(b + 2) % 8], 32'h81, "R2", "dd word1 addr");
    check(active, 1, "R2", "active");
    check(proceed, 0, "R2", "proceed after fetch");
    check(dd_len, 128, "R2", "len");
    check(dd_buf_addr, 32'h1000, "R2", "buf addr");
    check(dd_iso, 0, "R2", "iso");
    check(dd_ep, 3, "R2", "ep");
    check(dd_count, 0, "R2", "count start");
    pkt(64);
    check(dd_count, 64, "R7", "byte count");
    check(busy, 0, "R6", "idle after pkt");
    check(dd_retired, 0, "R8", "not retired");
  endtask

  task automatic t_proceed_then_retire;
    trig(3);
    check(t_reads, 0, "R4", "reuse reads");
    check(active, 1, "R4", "reuse active");
    check(proceed, 1, "R4", "reuse proceed");
    pkt(64);
    check(dd_count, 128, "R8", "full count");
    check(dd_retired, 1, "R8", "retired");
    check(proceed, 0, "R8", "proceed cleared");
    trig(3);
    check(t_reads, 3, "R8", "refetch reads");
    check(dd_count, 0, "R8", "refetch count");
    check(dd_retired, 0, "R8", "refetch retired");
    pkt(10);
    check(dd_count, 10, "R7", "byte count 10");
  endtask

  task automatic t_iso_and_switch;
    trig(5);
    check(t_reads, 3, "R9", "switch reads");
    check(proceed, 0, "R9", "switch proceed");
    check(dd_iso, 1, "R2", "iso flag");
    pkt(500);
    check(dd_count, 1, "R7", "iso count 1");
    trig(5);
    check(proceed, 1, "R4", "iso reuse");
    pkt(700);
    check(dd_count, 2, "R7", "iso count 2");
    check(dd_retired, 0, "R8", "iso not retired");
    trig(3);
    check(t_reads, 3, "R9", "back switch reads");
    check(proceed, 0, "R9", "back switch proceed");
    check(dd_ep, 3, "R9", "back switch ep");
    pkt(1);
  endtask

  task automatic t_bad_mode;
    trig(6);
    check(t_err, 1, "R5", "mode err");
    check(active, 0, "R5", "mode not active");
    check(busy, 0, "R5", "mode idle");
    check(t_reads, 2, "R5", "mode reads");
  endtask

  task automatic t_null_ptr;
    trig(7);
    check(t_err, 1, "R10", "null err");
    check(active, 0, "R10", "null not active");
    check(t_reads, 1, "R10", "null reads");
  endtask

  logic done = 1'b0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h43] = 32'h80;  mem[8'h80] = 32'h0080_0000; mem[8'h81] = 32'h1000;
    mem[8'h45] = 32'h90;  mem[8'h90] = 32'h0003_0004; mem[8'h91] = 32'h2000;
    mem[8'h46] = 32'hA0;  mem[8'hA0] = 32'h0040_0001; mem[8'hA1] = 32'h3000;
    mem[8'h47] = 32'h0;
    for (int k = 0; k < RD_LAT; k++) rpipe[k] = '0;
    dma_en = '0;
    dma_en[0] = 1'b1; dma_en[1] = 1'b1; dma_en[3] = 1'b1;
    dma_en[5] = 1'b1; dma_en[6] = 1'b1; dma_en[7] = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ctrl_refused;
    t_disabled;
    t_first_fetch;
    t_proceed_then_retire;
    t_iso_and_switch;
    t_bad_mode;
    t_null_ptr;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule